// File: doc/BRIEF.md
# CAN Acceptance Mask Filter

This block decides, for every frame identifier delivered by a CAN 2.0B receiver, which of sixteen receive message buffers would accept it. Each buffer holds a 29-bit identifier, a format flag (standard or extended) and an active flag. A frame is compared against every active buffer under an acceptance mask. Buffers 0 to 13 share one common mask. Buffers 14 and 15 each have a private mask with the same layout.

The receiver presents a decoded frame (identifier, format flag, remote-request flag) together with a one-cycle valid strobe. One clock later the block reports a per-buffer hit vector, the index of the lowest-numbered hit and a flag that is raised when nothing hit. Buffer identifiers, masks and active flags are written and read back over a plain 32-bit register port. Some bit positions of that port are tied to fixed values.

Top module: `can_accept_filter`

## Requirements
- R1: Mask registers sit at addresses 16 (shared mask for buffers 0-13), 17 (buffer 14) and 18 (buffer 15). They use this bit layout: bits 31..21 = mask ID[28:18], bits 18..16 = ID[17:15], bits 15..1 = ID[14:0]. Bits 0 and 20 always read 0 and bit 19 always reads 1, whatever was written. After reset every mask reads 0x0008_0000.
- R2: Buffer registers sit at addresses 0..15 and use the same identifier layout, with bit 19 holding the stored format flag (1 = extended). Bits 0 and 20 always read 0. Address 19 holds the active flags in bits 15..0 (bit n = buffer n), and its bits 31..16 read 0.
- R3: A mask bit of 1 requires the frame ID bit to equal the buffer ID bit. A mask bit of 0 makes that bit don't-care. For extended frames all 29 bits take part.
- R4: For a standard frame (frm_ide = 0) the 11-bit identifier is carried on frm_id[28:18]. Only mask bits ID[28:18] are applied, and frm_id[17:0] and buffer ID[17:0] have no effect.
- R5: The frame format flag is always compared with the buffer format flag, so a standard frame never hits an extended buffer and an extended frame never hits a standard buffer, whatever the mask.
- R6: A frame with frm_rtr = 1 never hits any buffer. For data frames the remote-request flag takes no part in the comparison.
- R7: Buffers 0 to 13 are filtered with the shared mask. Buffer 14 uses only its own mask, and buffer 15 uses only its own mask.
- R8: A buffer whose active flag is 0 never hits.
- R9: hit_idx gives the lowest-numbered buffer set in hit_vec. When hit_vec is zero, no_hit is 1 and hit_idx is 0.
- R10: hit_vec, hit_idx and no_hit are updated one clock after a cycle with frm_valid = 1, and res_valid is 1 in exactly that cycle. The outputs hold their values otherwise. A register write in the same cycle as frm_valid affects only later frames.
- R11: Reset (rst_n low, asynchronous) clears all buffer identifiers, format flags, active flags and masks, and drives res_valid, hit_vec, hit_idx and no_hit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| frm_valid | input | 1 | Frame presented this cycle |
| frm_id | input | 29 | Frame identifier (standard ID on [28:18]) |
| frm_ide | input | 1 | Frame format: 1 = extended |
| frm_rtr | input | 1 | Frame is a remote request |
| res_valid | output | 1 | Filter result produced this cycle |
| hit_vec | output | 16 | Per-buffer acceptance |
| hit_idx | output | 4 | Lowest accepting buffer |
| no_hit | output | 1 | No buffer accepted the frame |

## Verification
The filter result is registered once, so the bench drives a frame on a falling edge and checks hit_vec, hit_idx, no_hit and res_valid on the next falling edge, after the single capturing rising edge. On the falling edge after that, it checks that res_valid has dropped and that the result is held. Register reads are combinational and are checked a short delay after the address changes. A write is also issued in the same cycle as a frame, to show that the frame is still judged against the old mask and that only the next frame sees the new one.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int NBUF    = 16;
  localparam int ID_W    = 29;
  localparam int STD_W   = 11;
  localparam int EXT_W   = ID_W - STD_W;
  localparam int REG_W   = 32;
  localparam int NPRIV   = 2;
  localparam int B_IDE   = 19;

  // register word <-> identifier packing
  function automatic logic [ID_W-1:0] reg_to_id(input logic [REG_W-1:0] r);
    return {r[31:21], r[18:16], r[15:1]};
  endfunction

  function automatic logic [REG_W-1:0] id_to_reg(input logic [ID_W-1:0] id,
                                                 input logic ide);
    return {id[28:18], 1'b0, ide, id[17:15], id[14:0], 1'b0};
  endfunction

  // masked identifier equality; standard frames only see the base bits
  function automatic logic id_accept(input logic [ID_W-1:0] a,
                                     input logic [ID_W-1:0] b,
                                     input logic [ID_W-1:0] mask,
                                     input logic ext);
    logic [ID_W-1:0] eff;
    eff = ext ? mask : {mask[ID_W-1:EXT_W], {EXT_W{1'b0}}};
    return ((a ^ b) & eff) == '0;
  endfunction
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int NB     = NBUF,
  parameter int ADDR_W = $clog2(NB + NPRIV + 2),
  localparam int IW    = $clog2(NB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output logic [ID_W-1:0]      id_o   [NB],
  output logic [NB-1:0]        ide_o,
  output logic [NB-1:0]        act_o,
  output logic [ID_W-1:0]      mask_o [NPRIV+1]
);
  localparam logic [ADDR_W-1:0] AD_G   = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] AD_ACT = ADDR_W'(NB + NPRIV + 1);

  logic [ID_W-1:0] id_q   [NB];
  logic [NB-1:0]   ide_q, act_q;
  logic [ID_W-1:0] msk_q  [NPRIV+1];
  logic            sel_buf, sel_msk;
  logic [ADDR_W-1:0] moff;

  assign sel_buf = addr < AD_G;
  assign sel_msk = (addr >= AD_G) && (addr < AD_ACT);
  assign moff    = addr - AD_G;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) id_q[i] <= '0;
      for (int i = 0; i <= NPRIV; i++) msk_q[i] <= '0;
      ide_q <= '0;
      act_q <= '0;
    end else if (we) begin
      if (sel_buf) begin
        id_q[addr[IW-1:0]]  <= reg_to_id(wdata);
        ide_q[addr[IW-1:0]] <= wdata[B_IDE];
      end else if (sel_msk) begin
        msk_q[moff[1:0]] <= reg_to_id(wdata);
      end else if (addr == AD_ACT) begin
        act_q <= wdata[NB-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_buf)
      rdata = id_to_reg(id_q[addr[IW-1:0]], ide_q[addr[IW-1:0]]);
    else if (sel_msk)
      rdata = id_to_reg(msk_q[moff[1:0]], 1'b1);
    else if (addr == AD_ACT)
      rdata = REG_W'(act_q);
  end

  assign id_o   = id_q;
  assign ide_o  = ide_q;
  assign act_o  = act_q;
  assign mask_o = msk_q;
endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp
  import can_filt_pkg::*;
(
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ide,
  input  logic            frm_rtr,
  input  logic [ID_W-1:0] ref_id,
  input  logic            ref_ide,
  input  logic            ref_act,
  input  logic [ID_W-1:0] ref_mask,
  output logic            hit
);
  logic fmt_ok;
  assign fmt_ok = (frm_ide == ref_ide);
  assign hit    = ref_act & ~frm_rtr & fmt_ok &
                  id_accept(frm_id, ref_id, ref_mask, frm_ide);
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end
  assign none = ~|vec;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NB     = NBUF,
  localparam int ADDR_W = $clog2(NB + NPRIV + 2),
  localparam int IW     = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              frm_valid,
  input  logic [ID_W-1:0]   frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  output logic              res_valid,
  output logic [NB-1:0]     hit_vec,
  output logic [IW-1:0]     hit_idx,
  output logic              no_hit
);
  logic [ID_W-1:0] buf_id [NB];
  logic [ID_W-1:0] masks  [NPRIV+1];
  logic [NB-1:0]   ide_vec, act_vec, hit_now;
  logic [IW-1:0]   idx_now;
  logic            none_now;

  can_filt_regs #(.NB(NB), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .id_o(buf_id),
    .ide_o(ide_vec), .act_o(act_vec), .mask_o(masks)
  );

  // the last NPRIV buffers own a private mask, the rest share masks[0]
  for (genvar g = 0; g < NB; g++) begin : g_buf
    localparam int MSEL = (g >= NB - NPRIV) ? (g - (NB - NPRIV) + 1) : 0;
    can_filt_cmp u_cmp (
      .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
      .ref_id(buf_id[g]), .ref_ide(ide_vec[g]), .ref_act(act_vec[g]),
      .ref_mask(masks[MSEL]), .hit(hit_now[g])
    );
  end

  can_filt_prio #(.N(NB)) u_prio (.vec(hit_now), .idx(idx_now), .none(none_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      hit_vec   <= '0;
      hit_idx   <= '0;
      no_hit    <= 1'b0;
    end else begin
      res_valid <= frm_valid;
      if (frm_valid) begin
        hit_vec <= hit_now;
        hit_idx <= idx_now;
        no_hit  <= none_now;
      end
    end
  end
endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk #(
  parameter int NB     = 16,
  parameter int ADDR_W = 5,
  localparam int IW    = $clog2(NB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              frm_valid,
  input logic              frm_ide,
  input logic              frm_rtr,
  input logic              res_valid,
  input logic [NB-1:0]     hit_vec,
  input logic [IW-1:0]     hit_idx,
  input logic              no_hit,
  input logic [NB-1:0]     act_vec,
  input logic [NB-1:0]     ide_vec
);
  logic is_mask_addr;
  assign is_mask_addr = (cfg_addr >= ADDR_W'(NB)) && (cfg_addr <= ADDR_W'(NB + 2));

  always_comb begin
    if (rst_n && is_mask_addr)
      assert_mask_fixed_R1: assert (cfg_rdata[0] == 1'b0 && cfg_rdata[20] == 1'b0 && cfg_rdata[19] == 1'b1);
  end

  assert_rtr_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_rtr |=> hit_vec == '0);

  assert_ide_compare_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (hit_vec & ($past(frm_ide) ? ~$past(ide_vec) : $past(ide_vec))) == '0);

  assert_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (hit_vec & ~$past(act_vec)) == '0);

  assert_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !no_hit |-> hit_vec[hit_idx] && ((hit_vec & ((NB'(1) << hit_idx) - NB'(1))) == '0));

  assert_nohit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (no_hit == (hit_vec == '0)) && (!no_hit || hit_idx == '0));

  assert_res_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);

  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !res_valid && $stable(hit_vec) && $stable(hit_idx) && $stable(no_hit));
endmodule

bind can_accept_filter can_filt_chk #(.NB(NB), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .frm_valid(frm_valid), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
  .res_valid(res_valid), .hit_vec(hit_vec), .hit_idx(hit_idx), .no_hit(no_hit),
  .act_vec(act_vec), .ide_vec(ide_vec)
);

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic        res_valid, no_hit;
  logic [15:0] hit_vec;
  logic [3:0]  hit_idx;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the programmed state
  logic [28:0] m_id [NB];
  logic [NB-1:0] m_ide, m_act;
  logic [28:0] m_mask [3];

  can_accept_filter dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [28:0] id, input logic ide);
    logic [31:0] r = '0;
    for (int i = 0; i < 29; i++) begin
      int p = (i < 15) ? i + 1 : (i < 18) ? i + 1 : i + 3;
      r[p] = id[i];
    end
    r[19] = ide;
    return r;
  endfunction

  function automatic logic [28:0] dec(input logic [31:0] r);
    return {r[31:21], r[18:1]} & 29'h1FFF_FFFF;
  endfunction

  function automatic bit ref_hit(input int b, input logic [28:0] id,
                                 input logic ide, input logic rtr);
    logic [28:0] mk;
    if (!m_act[b] || rtr || ide != m_ide[b]) return 0;
    mk = (b == 14) ? m_mask[1] : (b == 15) ? m_mask[2] : m_mask[0];
    for (int i = 0; i < 29; i++) begin
      if (!ide && i < 18) continue;
      if (mk[i] && id[i] != m_id[b][i]) return 0;
    end
    return 1;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 16) begin m_id[a] = dec(d); m_ide[a] = d[19]; end
    else if (a <= 18) m_mask[a-16] = dec(d);
    else if (a == 19) m_act = d[15:0];
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    cfg_addr = 5'(a);
    #1;
    chk(cfg_rdata === exp, req, "readback", cfg_rdata, exp);
  endtask

  task automatic send_chk(input logic [28:0] id, input logic ide,
                          input logic rtr, input string req);
    logic [15:0] ev = '0;
    int ei = 0;
    for (int b = 0; b < NB; b++) ev[b] = ref_hit(b, id, ide, rtr);
    for (int b = NB - 1; b >= 0; b--) if (ev[b]) ei = b;
    @(negedge clk);
    frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    @(negedge clk);
    frm_valid = 1'b0;
    chk(res_valid === 1'b1, "R10", "res_valid", 32'(res_valid), 1);
    chk(hit_vec === ev, req, "hit_vec", 32'(hit_vec), 32'(ev));
    chk(hit_idx === 4'(ei) && no_hit === (ev == 0), "R9", "idx/none",
        {hit_idx, 3'b0, no_hit}, {4'(ei), 3'b0, ev == 0});
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [28:0] base;
    void'($urandom(32'd1357));
    for (int b = 0; b < NB; b++) begin m_id[b] = '0; end
    m_ide = '0; m_act = '0;
    for (int k = 0; k < 3; k++) m_mask[k] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(res_valid === 0 && hit_vec === 0 && hit_idx === 0 && no_hit === 0,
        "R11", "outputs after reset", {hit_vec, hit_idx, res_valid, no_hit}, 0);
    rd_chk(16, 32'h0008_0000, "R11");
    rd_chk(3, 32'h0, "R11");
    rd_chk(19, 32'h0, "R11");

    // R1 fixed mask bits
    wr(16, 32'hFFFF_FFFF);
    rd_chk(16, 32'hFFEF_FFFE, "R1");
    wr(17, 32'h0);
    rd_chk(17, 32'h0008_0000, "R1");
    // R2 buffer and active readback
    wr(5, 32'hFFFF_FFFF);
    rd_chk(5, 32'hFFEF_FFFE, "R2");
    wr(19, 32'hFFFF_FFFF);
    rd_chk(19, 32'h0000_FFFF, "R2");

    // directed: clean slate
    for (int b = 0; b < NB; b++) wr(b, enc(29'(b * 29'h0123457), 1'b1));
    wr(16, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF); wr(18, 32'hFFFF_FFFF);
    wr(19, 32'hFFFF);
    send_chk(m_id[7], 1'b1, 1'b0, "R3");                    // exact hit
    send_chk(m_id[7] ^ 29'h1, 1'b1, 1'b0, "R3");            // one bit off
    send_chk(m_id[7], 1'b1, 1'b1, "R6");                    // remote frame
    send_chk(m_id[7], 1'b0, 1'b0, "R5");                    // format differs
    wr(3, enc(29'h155 << 18, 1'b0));
    send_chk((29'h155 << 18) | 29'h2_ABCD, 1'b0, 1'b0, "R4"); // low bits ignored
    wr(16, 32'h0);                                          // shared: accept all
    send_chk(m_id[14], 1'b1, 1'b0, "R7");                   // 0..13 ext + 14
    send_chk(m_id[15] ^ 29'h100, 1'b1, 1'b0, "R7");         // 15 misses by own mask
    wr(19, 32'h0000_3FF0);
    send_chk(m_id[2], 1'b1, 1'b0, "R8");                    // 0..3 inactive
    // R10: idle cycle holds result
    @(negedge clk);
    chk(res_valid === 0, "R10", "res_valid idle", 32'(res_valid), 0);
    chk(hit_vec === 16'h3FF0 && hit_idx === 4 && no_hit === 0, "R10",
        "held result", {hit_vec, hit_idx}, {16'h3FF0, 4'd4});
    // R10: write in the same cycle as a frame uses the old mask
    frm_valid = 1'b1; frm_id = 29'h0; frm_ide = 1'b1; frm_rtr = 1'b0;
    cfg_we = 1'b1; cfg_addr = 5'd16; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    frm_valid = 1'b0; cfg_we = 1'b0;
    chk(hit_vec === 16'h3FF0, "R10", "old mask applies", 32'(hit_vec), 32'h3FF0);
    m_mask[0] = 29'h1FFF_FFFF;
    send_chk(29'h0, 1'b1, 1'b0, "R10");                     // new mask now

    // constrained random
    for (int it = 0; it < 400; it++) begin
      if (it % 50 == 0) begin
        base = 29'($urandom);
        for (int b = 0; b < NB; b++)
          wr(b, enc(base ^ (29'($urandom) & 29'h0000_0C03) ^ ((b % 3 == 0) ? 29'h0 : 29'($urandom) & 29'h1800_0000),
                    1'($urandom % 4 != 0)));
        for (int k = 16; k <= 18; k++)
          wr(k, $urandom | $urandom);
        wr(19, $urandom | $urandom);
      end
      begin
        int pick = $urandom % NB;
        logic [28:0] id = m_id[pick] ^ (($urandom % 3 == 0) ? 29'($urandom) & 29'($urandom) : 29'h0);
        logic ide = ($urandom % 5 == 0) ? ~m_ide[pick] : m_ide[pick];
        logic rtr = ($urandom % 8 == 0);
        send_chk(id, ide, rtr, "R3/R5/R7");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule